// File: doc/BRIEF.md
# SPDIF Channel Status Double Buffer

This block gathers the channel status bits carried by a decoded SPDIF/AES3 stream. Each subframe delivers one status bit together with a channel marker (A or B) and, on the first subframe of a block, a block-start marker. Over one block of 192 frames the bits for both channels are packed into a working buffer. When the last subframe of the block has arrived, both channels are copied into a host-visible pair of banks in one step. Because of this, the host never sees a mix of two blocks.

The host reads the status bytes through a small byte-wide register port. A configuration register decides which channel's 24 bytes appear in the status window, and whether the interrupt flag tracks every finished block or only blocks whose leading five bytes differ from the copy being replaced. The flag drives an interrupt output and is cleared by the host.

Top module: `spdif_cs_dbuf`

## Requirements
- R1: With `sf_valid` high, the status bit of channel A (`sf_chan`=0) in frame k of a block becomes bit k of the channel A bank, and the channel B bit (`sf_chan`=1) of frame k becomes bit k of the B bank. Bit k lands in status byte k/8 at bit position k%8. Cycles with `sf_valid` low have no effect.
- R2: The host-visible banks keep their contents until the channel B subframe of frame 191 has been taken. Both banks then update together, and the new contents are readable after the second rising edge following that subframe.
- R3: A channel A subframe with `sf_blk_start` high restarts collection at frame 0 and discards any partial block. Subframes that arrive with no block in progress (after reset, or after a completed block) are ignored.
- R4: Reads of addresses 0x20 to 0x37 return status byte (address - 0x20) of the bank chosen by the configuration bit 0 (0 = channel A, 1 = channel B). Reads of any unmapped address return 0.
- R5: The configuration register at 0x1E holds the bank select in bit 0 and the interrupt mode in bit 1. It reads back these two bits, with bits 7:2 reading 0.
- R6: In interrupt mode 0, every completed block sets the interrupt flag.
- R7: In interrupt mode 1, a completed block sets the flag only if status bytes 0 to 4 of channel A or channel B differ from the values that block replaces.
- R8: The flag reads as bit 0 of address 0x1F and drives `cs_irq`. Writing 1 to bit 0 of 0x1F clears it, and writing 0 leaves it unchanged. A block completing in the same cycle as a clear leaves the flag set.
- R9: Reset (`rst_n` low at a rising edge) clears both banks, the working buffer, the configuration register and the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sf_valid | input | 1 | A subframe's status bit is present this cycle |
| sf_chan | input | 1 | Channel of the subframe: 0 = A, 1 = B |
| sf_blk_start | input | 1 | Subframe is the first of a block (honoured on channel A) |
| sf_cs_bit | input | 1 | Channel status bit of the subframe |
| host_addr | input | 8 | Host register address |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for `host_addr` (combinational) |
| cs_irq | output | 1 | Status-buffer interrupt flag |

## Verification
The bench builds the block with its default parameters: a 192-frame block, a five-byte comparison window and the register addresses given above. With these values it drives full-length blocks, so every one of the 24 bytes in both banks is written and read back. The comparison window covers exactly bytes 0 to 4, so a change in byte 3 and a change in byte 10 fall on opposite sides of its edge. Random idle gaps, early restarts and stray subframes between blocks show whether the copy step waits for the true last subframe.

// File: rtl/spdif_cs_pkg.sv
// Package: shared types for the channel status double buffer.
// Assumes a byte-wide host port; the configuration register layout lives here.
package spdif_cs_pkg;

    localparam int BYTE_W = 8;

    // Host configuration register: bank select in bit 0, interrupt mode in bit 1.
    typedef struct packed {
        logic lead_mode;   // 1: flag only on change of the leading bytes
        logic show_b;      // 1: status window shows channel B
    } cs_cfg_t;

endpackage

// File: rtl/cs_frame_tracker.sv
// cs_frame_tracker: follows frame position inside a status block.
// Assumes channel A precedes channel B within a frame and that the block-start
// marker comes with the channel A subframe of frame 0. Produces the write strobe
// and bit index for the working buffer and a one-cycle commit pulse registered
// after the last channel B subframe of the block.
module cs_frame_tracker #(
    parameter int FRAMES = 192,
    localparam int IDX_W = $clog2(FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sf_valid,
    input  logic             sf_chan,
    input  logic             sf_blk_start,
    output logic             bit_we,
    output logic [IDX_W-1:0] bit_idx,
    output logic             commit
);

    localparam logic [IDX_W-1:0] LAST_FRAME = IDX_W'(FRAMES - 1);

    logic             in_block;
    logic [IDX_W-1:0] frame_cnt;
    logic             start_hit;
    logic             last_sub;

    // Decode a block start, whether this subframe is taken, and the final subframe.
    always_comb begin
        start_hit = sf_valid && sf_blk_start && !sf_chan;
        bit_we    = sf_valid && (start_hit || in_block);
        bit_idx   = start_hit ? '0 : frame_cnt;
        last_sub  = bit_we && !start_hit && sf_chan && (frame_cnt == LAST_FRAME);
    end

    // Advance the frame counter and track whether a block is being collected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_block  <= 1'b0;
            frame_cnt <= '0;
            commit    <= 1'b0;
        end else begin
            commit <= last_sub;
            if (start_hit) begin
                in_block  <= 1'b1;
                frame_cnt <= '0;
            end else if (bit_we && sf_chan) begin
                if (last_sub) begin
                    in_block  <= 1'b0;
                    frame_cnt <= '0;
                end else begin
                    frame_cnt <= frame_cnt + 1'b1;
                end
            end
        end
    end

    // R1: the frame position never leaves the block.
    p_frame_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_cnt <= LAST_FRAME);

    // R3: a commit only follows a cycle in which a block was in progress.
    p_commit_in_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(in_block));

    // R3: outside a block, nothing is written unless a block starts.
    p_idle_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_block && !(sf_valid && sf_blk_start && !sf_chan)) |-> !bit_we);

endmodule

// File: rtl/cs_bank_store.sv
// cs_bank_store: working buffer plus host-visible banks for both channels.
// Assumes at most one bit write per cycle. On commit the whole working buffer
// is copied to the host banks; lead_diff reports whether the leading bytes of
// either channel differ between working and host copies at that moment.
module cs_bank_store #(
    parameter int FRAMES     = 192,
    parameter int LEAD_BYTES = 5,
    localparam int IDX_W     = $clog2(FRAMES),
    localparam int LEAD_BITS = LEAD_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_we,
    input  logic              bit_chan,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic              bit_val,
    input  logic              commit,
    output logic [FRAMES-1:0] host_a,
    output logic [FRAMES-1:0] host_b,
    output logic              lead_diff
);

    logic [FRAMES-1:0] work_a;
    logic [FRAMES-1:0] work_b;

    // Place each incoming status bit into the working buffer of its channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_a <= '0;
            work_b <= '0;
        end else if (bit_we) begin
            if (bit_chan) begin
                work_b[bit_idx] <= bit_val;
            end else begin
                work_a[bit_idx] <= bit_val;
            end
        end
    end

    // Copy both working channels to the host banks at the end of a block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_a <= '0;
            host_b <= '0;
        end else if (commit) begin
            host_a <= work_a;
            host_b <= work_b;
        end
    end

    // Compare the leading bytes of the block about to be copied with the current copy.
    always_comb begin
        lead_diff = (work_a[LEAD_BITS-1:0] != host_a[LEAD_BITS-1:0]) ||
                    (work_b[LEAD_BITS-1:0] != host_b[LEAD_BITS-1:0]);
    end

    // R2: host banks only move on a commit.
    p_host_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(host_a) && $stable(host_b)));

    // R2: after a commit the host banks hold what the working buffer held.
    p_host_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (host_a == $past(work_a) && host_b == $past(work_b)));

endmodule

// File: rtl/cs_host_regs.sv
// cs_host_regs: configuration register, interrupt flag and read multiplexer.
// Assumes reads are combinational from host_addr and writes take effect at the
// clock edge. The flag's set condition has priority over a host clear.
module cs_host_regs
    import spdif_cs_pkg::*;
#(
    parameter int              FRAMES    = 192,
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 8'h20,
    parameter logic [ADDR_W-1:0] CFG_ADDR  = 8'h1E,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h1F,
    localparam int             NBYTES    = FRAMES / 8,
    localparam int             BSEL_W    = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              commit,
    input  logic              lead_diff,
    input  logic [FRAMES-1:0] host_a,
    input  logic [FRAMES-1:0] host_b,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              cs_irq
);

    localparam logic [ADDR_W-1:0] WIN_END = WIN_BASE + ADDR_W'(NBYTES);

    cs_cfg_t           cfg;
    logic              flag;
    logic              clr_req;
    logic              set_req;
    logic [BYTE_W-1:0] bytes_a [NBYTES];
    logic [BYTE_W-1:0] bytes_b [NBYTES];
    logic [ADDR_W-1:0] win_off;
    logic              in_win;
    logic              unused_wdata;
    logic              unused_off;

    // Split each flat bank into addressable bytes.
    for (genvar g = 0; g < NBYTES; g++) begin : g_bytes
        assign bytes_a[g] = host_a[g*8 +: 8];
        assign bytes_b[g] = host_b[g*8 +: 8];
    end

    assign unused_wdata = ^host_wdata[BYTE_W-1:2];
    assign unused_off   = ^win_off[ADDR_W-1:BSEL_W];

    // Decode the flag set and clear requests for this cycle.
    always_comb begin
        clr_req = host_wr && (host_addr == STAT_ADDR) && host_wdata[0];
        set_req = commit && (!cfg.lead_mode || lead_diff);
    end

    // Hold the configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (host_wr && (host_addr == CFG_ADDR)) begin
            cfg <= cs_cfg_t'(host_wdata[1:0]);
        end
    end

    // Maintain the sticky interrupt flag; a new event outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_req) begin
            flag <= 1'b1;
        end else if (clr_req) begin
            flag <= 1'b0;
        end
    end

    // Select the read data for the current host address.
    always_comb begin
        win_off    = host_addr - WIN_BASE;
        in_win     = (host_addr >= WIN_BASE) && (host_addr < WIN_END);
        host_rdata = '0;
        if (in_win) begin
            host_rdata = cfg.show_b ? bytes_b[win_off[BSEL_W-1:0]]
                                    : bytes_a[win_off[BSEL_W-1:0]];
        end else if (host_addr == CFG_ADDR) begin
            host_rdata = {{(BYTE_W-2){1'b0}}, cfg};
        end else if (host_addr == STAT_ADDR) begin
            host_rdata = {{(BYTE_W-1){1'b0}}, flag};
        end
    end

    assign cs_irq = flag;

    // R6: in mode 0 every commit leaves the flag set.
    p_every_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !cfg.lead_mode) |=> cs_irq);

    // R7: in mode 1 an unchanged lead does not raise a clear flag.
    p_quiet_lead_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && cfg.lead_mode && !lead_diff && !cs_irq) |=> !cs_irq);

    // R8: a clear with no competing commit drops the flag.
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == STAT_ADDR && host_wdata[0] && !commit) |=> !cs_irq);

    // R8: the flag only rises after a commit.
    p_rise_on_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_irq) |-> $past(commit));

endmodule

// File: rtl/spdif_cs_dbuf.sv
// spdif_cs_dbuf: channel status double buffer for a decoded SPDIF/AES3 stream.
// Assumes one subframe status bit per sf_valid cycle, channel A before B in each
// frame, and a block-start marker on the first channel A subframe of a block.
// Collects a full block, copies it to the host banks, and serves host reads.
module spdif_cs_dbuf
    import spdif_cs_pkg::*;
#(
    parameter int                FRAMES     = 192,
    parameter int                LEAD_BYTES = 5,
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] WIN_BASE   = 8'h20,
    parameter logic [ADDR_W-1:0] CFG_ADDR   = 8'h1E,
    parameter logic [ADDR_W-1:0] STAT_ADDR  = 8'h1F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sf_valid,
    input  logic              sf_chan,
    input  logic              sf_blk_start,
    input  logic              sf_cs_bit,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              cs_irq
);

    localparam int IDX_W = $clog2(FRAMES);

    logic              bit_we;
    logic [IDX_W-1:0]  bit_idx;
    logic              commit;
    logic [FRAMES-1:0] host_a;
    logic [FRAMES-1:0] host_b;
    logic              lead_diff;

    cs_frame_tracker #(.FRAMES(FRAMES)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .sf_valid     (sf_valid),
        .sf_chan      (sf_chan),
        .sf_blk_start (sf_blk_start),
        .bit_we       (bit_we),
        .bit_idx      (bit_idx),
        .commit       (commit)
    );

    cs_bank_store #(.FRAMES(FRAMES), .LEAD_BYTES(LEAD_BYTES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_we    (bit_we),
        .bit_chan  (sf_chan),
        .bit_idx   (bit_idx),
        .bit_val   (sf_cs_bit),
        .commit    (commit),
        .host_a    (host_a),
        .host_b    (host_b),
        .lead_diff (lead_diff)
    );

    cs_host_regs #(
        .FRAMES    (FRAMES),
        .ADDR_W    (ADDR_W),
        .WIN_BASE  (WIN_BASE),
        .CFG_ADDR  (CFG_ADDR),
        .STAT_ADDR (STAT_ADDR)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .commit     (commit),
        .lead_diff  (lead_diff),
        .host_a     (host_a),
        .host_b     (host_b),
        .host_rdata (host_rdata),
        .cs_irq     (cs_irq)
    );

endmodule

// File: tb/spdif_cs_dbuf_test.sv
`timescale 1ns/1ps
module spdif_cs_dbuf_test;

    localparam int FR = 192;
    localparam int NB = FR / 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sf_valid = 1'b0;
    logic       sf_chan = 1'b0;
    logic       sf_blk_start = 1'b0;
    logic       sf_cs_bit = 1'b0;
    logic [7:0] host_addr = 8'h00;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       cs_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    bit nxt_a [FR];
    bit nxt_b [FR];
    bit mdl_a [FR];
    bit mdl_b [FR];
    bit exp_flag = 1'b0;

    spdif_cs_dbuf uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sf_valid     (sf_valid),
        .sf_chan      (sf_chan),
        .sf_blk_start (sf_blk_start),
        .sf_cs_bit    (sf_cs_bit),
        .host_addr    (host_addr),
        .host_wr      (host_wr),
        .host_wdata   (host_wdata),
        .host_rdata   (host_rdata),
        .cs_irq       (cs_irq)
    );

    always #2 clk = ~clk;

    function automatic logic [7:0] exp_byte(bit ch, int i);
        logic [7:0] v;
        for (int b = 0; b < 8; b++) v[b] = ch ? mdl_b[i*8+b] : mdl_a[i*8+b];
        return v;
    endfunction

    function automatic bit lead_changed();
        bit d = 1'b0;
        for (int k = 0; k < 40; k++) begin
            if (nxt_a[k] != mdl_a[k] || nxt_b[k] != mdl_b[k]) d = 1'b1;
        end
        return d;
    endfunction

    task automatic check8(string req, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic check_bank(string req, bit ch, logic [7:0] mode_bit);
        logic [7:0] d;
        wr(8'h1E, {6'b0, mode_bit[0], ch});
        for (int i = 0; i < NB; i++) begin
            rd(8'(8'h20 + i), d);
            check8(req, $sformatf("bank %0d byte %0d", ch, i), d, exp_byte(ch, i));
        end
    endtask

    task automatic check_flag(string req);
        logic [7:0] d;
        rd(8'h1F, d);
        check8(req, "flag register", d, {7'b0, exp_flag});
        check8(req, "irq pin", {7'b0, cs_irq}, {7'b0, exp_flag});
    endtask

    task automatic randomize_next();
        for (int k = 0; k < FR; k++) begin
            nxt_a[k] = 1'($urandom());
            nxt_b[k] = 1'($urandom());
        end
    endtask

    // Drive nframes frames; optional start marker, random idle gaps, and a
    // flag-clear write timed to the commit edge.
    task automatic send(int nframes, bit with_start, bit gaps, bit clr_at_commit);
        for (int f = 0; f < nframes; f++) begin
            for (int c = 0; c < 2; c++) begin
                @(negedge clk);
                sf_valid     = 1'b1;
                sf_chan      = 1'(c);
                sf_blk_start = (c == 0) && (f == 0) && with_start;
                sf_cs_bit    = (c == 0) ? nxt_a[f] : nxt_b[f];
                if (gaps && ($urandom() % 4 == 0)) begin
                    @(negedge clk);
                    sf_valid     = 1'b0;
                    sf_chan      = 1'b0;
                    sf_blk_start = 1'b1;
                    sf_cs_bit    = 1'($urandom());
                end
            end
        end
        @(negedge clk);
        sf_valid = 1'b0; sf_blk_start = 1'b0;
        if (clr_at_commit) begin
            host_addr = 8'h1F; host_wdata = 8'h01; host_wr = 1'b1;
        end
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic commit_model(bit lead_mode);
        if (!lead_mode || lead_changed()) exp_flag = 1'b1;
        for (int k = 0; k < FR; k++) begin
            mdl_a[k] = nxt_a[k];
            mdl_b[k] = nxt_b[k];
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog R2: run hung, actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h5EED));
        for (int k = 0; k < FR; k++) begin
            mdl_a[k] = 1'b0; mdl_b[k] = 1'b0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state
        rd(8'h1E, d); check8("R9", "cfg after reset", d, 8'h00);
        check_flag("R9");
        check_bank("R9", 1'b0, 8'h0);
        check_bank("R9", 1'b1, 8'h0);

        // R1 R4 R6: one full random block, mode 0
        randomize_next();
        send(FR, 1'b1, 1'b0, 1'b0);
        commit_model(1'b0);
        check_bank("R1", 1'b0, 8'h0);
        check_bank("R4", 1'b1, 8'h0);
        check_flag("R6");

        // R8: writing 0 keeps the flag, writing 1 clears it
        wr(8'h1F, 8'h00); check_flag("R8");
        wr(8'h1F, 8'h01); exp_flag = 1'b0; check_flag("R8");

        // R3: subframes with no block in progress are ignored
        randomize_next();
        send(FR, 1'b0, 1'b0, 1'b0);
        check_bank("R3", 1'b0, 8'h0);
        check_flag("R3");

        // R2: a partial block leaves the host banks untouched
        randomize_next();
        send(100, 1'b1, 1'b0, 1'b0);
        check_bank("R2", 1'b0, 8'h0);
        check_bank("R2", 1'b1, 8'h0);
        check_flag("R2");

        // R3 R1: restart mid-block, with idle gaps, then a full block
        randomize_next();
        send(FR, 1'b1, 1'b1, 1'b0);
        commit_model(1'b0);
        check_bank("R3", 1'b0, 8'h0);
        check_bank("R1", 1'b1, 8'h0);
        check_flag("R6");
        wr(8'h1F, 8'h01); exp_flag = 1'b0;

        // R5: configuration read-back
        wr(8'h1E, 8'hFE); rd(8'h1E, d); check8("R5", "cfg readback", d, 8'h02);
        wr(8'h1E, 8'h03); rd(8'h1E, d); check8("R5", "cfg readback", d, 8'h03);

        // R4: unmapped addresses read 0
        rd(8'h38, d); check8("R4", "addr 0x38", d, 8'h00);
        rd(8'h10, d); check8("R4", "addr 0x10", d, 8'h00);

        // R7: mode 1, identical block does not raise the flag
        for (int k = 0; k < FR; k++) begin
            nxt_a[k] = mdl_a[k]; nxt_b[k] = mdl_b[k];
        end
        send(FR, 1'b1, 1'b0, 1'b0);
        commit_model(1'b1);
        check_flag("R7");

        // R7: change outside the leading bytes (byte 10 of A): data moves, no flag
        nxt_a[83] = ~nxt_a[83];
        send(FR, 1'b1, 1'b1, 1'b0);
        commit_model(1'b1);
        check_flag("R7");
        check_bank("R7", 1'b0, 8'h1);

        // R7: change in byte 3 of B raises the flag
        nxt_b[29] = ~nxt_b[29];
        send(FR, 1'b1, 1'b0, 1'b0);
        commit_model(1'b1);
        check_flag("R7");
        check_bank("R7", 1'b1, 8'h1);

        // R8: a clear in the commit cycle loses to the new block (mode 0)
        wr(8'h1E, 8'h00);
        randomize_next();
        send(FR, 1'b1, 1'b0, 1'b1);
        commit_model(1'b0);
        check_flag("R8");
        wr(8'h1F, 8'h01); exp_flag = 1'b0; check_flag("R8");

        // R1 R2: random blocks with gaps, mode 0
        for (int n = 0; n < 3; n++) begin
            randomize_next();
            send(FR, 1'b1, 1'b1, 1'b0);
            commit_model(1'b0);
            check_bank("R1", 1'b0, 8'h0);
            check_bank("R2", 1'b1, 8'h0);
            check_flag("R6");
            wr(8'h1F, 8'h01); exp_flag = 1'b0;
        end

        // R9: reset mid-run clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int k = 0; k < FR; k++) begin
            mdl_a[k] = 1'b0; mdl_b[k] = 1'b0;
        end
        exp_flag = 1'b0;
        rd(8'h1E, d); check8("R9", "cfg after reset", d, 8'h00);
        check_bank("R9", 1'b0, 8'h0);
        check_bank("R9", 1'b1, 8'h0);
        check_flag("R9");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule